// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

The block gathers up to 64 active-low interrupt inputs into one request line for a processor. Software sees each source through a fixed, deliberately non-linear placement in a pair of 32-bit enable words and a pair of 32-bit pending words, reached over a simple register port with a write strobe. A read of the vector register returns the number of the source that should be serviced next.

Each source belongs to one of three sense classes. Fixed internal sources are always level-sensitive and active low. Seven external-pin sources can each be switched between level-low and falling-edge detection. Sixteen port sources can each be switched between falling-edge-only and both-edge detection. Every input passes through a synchronizer before detection. Edge events stay latched until software clears them by writing ones. Two priority words and a narrow configuration word are only stored and read back. The service order is fixed: the lowest source number wins.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset both enable words, both pending words and the sense word read 0, the vector reads 0, irq_o is low, both priority words read 0x05309770 and the configuration word reads 0.
- R2: Source s has the physical bit p(s) = 32*word + bit. Sources 1..15 map to p = 16-s. Sources 16..18 map to p = 50-s. Sources 19..30 map to p = 65-s. Source 31 maps to p = 47. Sources 32..47 map to p = 63-s. Sources 48..63 map to p = s. Source 0 owns p = 0. The low word holds p 0..31 and the high word holds p 32..63.
- R3: irq_o is high exactly when some source has both its pending bit and its enable bit (1 = enabled, at p(s)) set.
- R4: A level-mode source's pending bit equals the inverse of its input, delayed by three clock edges. Writing ones over it has no effect.
- R5: External sources 19..25 use sense bit 33-s. When that bit is 1, a falling input sets the pending bit, and the bit stays set until a one is written to it. When the bit is 0, the source behaves as in R4.
- R6: Port sources 48..63 are always latched and use sense bit s-32. When that bit is 1, only a falling input sets the pending bit. When it is 0, both a falling and a rising input set it.
- R7: Writing the pending words at address 2 (low) or 3 (high) clears the latched edge bits whose written bit is 1. Latched bits whose written bit is 0 are left as they are.
- R8: The vector register at address 5 holds, in bits 31:26, the lowest source number that is pending and enabled, and 0 when there is none. All its other bits read 0.
- R9: Source 0 never becomes pending, whatever its input does.
- R10: The sense word at address 4 stores only bits 8..14 and 16..31. Writing all ones reads back 0xFFFF7F00.
- R11: The priority words at addresses 6 and 7 store all 32 bits. The configuration word at address 8 stores its low 16 bits, and its upper bits read 0.
- R12: The enable words are at address 0 (low) and 1 (high) and change only when written. A write to the vector address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 64 | Interrupt inputs, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong entry in the placement map shows up on the next read of a pending word: the bit lands in the wrong place, or a second source lands on top of it. The vector then also points at a different source. A latched bit that is wrong, whether lost, stuck or cleared by a write that missed it, is visible three edges after the input change or at once after the clearing write, both in the pending words and in irq_o. A sense bit that selects the wrong mode shows only when the input goes back to its idle level. For that reason the bench reads the pending words after both edges of each pulse.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_SRC  = 64;
  localparam int WORD_W   = 32;
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int ADDR_W   = 4;

  typedef enum logic [1:0] {CLS_FIXED, CLS_EXT, CLS_PORT} src_cls_e;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_LO = 4'd0, A_MASK_HI = 4'd1, A_PEND_LO = 4'd2, A_PEND_HI = 4'd3,
    A_SENSE   = 4'd4, A_VEC     = 4'd5, A_PRIO_A  = 4'd6, A_PRIO_B  = 4'd7,
    A_CFG     = 4'd8
  } reg_addr_e;

  // physical bit = 32*word + bit, bijective over 0..63
  function automatic int phys_idx(input int s);
    if (s == 0)       return 0;
    else if (s < 16)  return 16 - s;
    else if (s < 19)  return 50 - s;
    else if (s < 31)  return 65 - s;
    else if (s == 31) return 47;
    else if (s < 48)  return 63 - s;
    else              return s;
  endfunction

  function automatic src_cls_e src_class(input int s);
    if (s >= 19 && s <= 25) return CLS_EXT;
    if (s >= 48 && s <= 63) return CLS_PORT;
    return CLS_FIXED;
  endfunction

  function automatic int sense_pos(input int s);
    case (src_class(s))
      CLS_EXT:  return 33 - s;
      CLS_PORT: return s - 32;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sense_valid();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_class(s) != CLS_FIXED) m[sense_pos(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int NUM   = 64,
  parameter int DEPTH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] async_ni,
  output logic [NUM-1:0] lvl_o,
  output logic [NUM-1:0] fall_o,
  output logic [NUM-1:0] rise_o
);
  logic [NUM-1:0] stage_q [DEPTH];
  logic [NUM-1:0] prev_q;

  for (genvar d = 0; d < DEPTH; d++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[d] <= '1;
      else if (d == 0) stage_q[d] <= async_ni;
      else             stage_q[d] <= stage_q[(d == 0) ? 0 : d-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= stage_q[DEPTH-1];
  end

  assign lvl_o  = stage_q[DEPTH-1];
  assign fall_o = prev_q & ~stage_q[DEPTH-1];
  assign rise_o = ~prev_q & stage_q[DEPTH-1];
endmodule

// File: rtl/sirq_pend.sv
module sirq_pend
  import sirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] fall_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [WORD_W-1:0]  sense_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam src_cls_e CLS = src_class(s);
    localparam int       SP  = sense_pos(s);
    if (s == 0) begin : g_rsvd
      assign pend_o[s] = 1'b0;
    end else begin : g_live
      logic q;
      if (CLS == CLS_FIXED) begin : g_fix
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= ~lvl_i[s];
        end
      end else if (CLS == CLS_EXT) begin : g_ext
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)         q <= 1'b0;
          else if (sense_i[SP]) q <= fall_i[s] | (q & ~clr_i[s]);
          else                 q <= ~lvl_i[s];
        end
      end else begin : g_port
        logic det;
        assign det = fall_i[s] | (~sense_i[SP] & rise_i[s]);
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= det | (q & ~clr_i[s]);
        end
      end
      assign pend_o[s] = q;
    end
  end
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
  parameter int NUM  = 64,
  parameter int ID_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]  req_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = NUM - 1; i >= 0; i--)
      if (req_i[i]) id_o = i[ID_W-1:0];
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter logic [WORD_W-1:0] PRIO_RST   = 32'h0530_9770,
  parameter int                CFG_W      = 16,
  parameter int                SYNC_DEPTH = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam logic [WORD_W-1:0] SENSE_OK = sense_valid();

  logic [2*WORD_W-1:0] mask_q, pend_phys, clr_phys;
  logic [WORD_W-1:0]   sense_q, prio_a_q, prio_b_q;
  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_SRC-1:0]  lvl, fall, rise, pend_src, mask_src, clr_src;
  logic [ID_W-1:0]     vec_id;
  logic                any_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      sense_q  <= '0;
      prio_a_q <= PRIO_RST;
      prio_b_q <= PRIO_RST;
      cfg_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK_LO: mask_q[WORD_W-1:0]        <= wdata_i;
        A_MASK_HI: mask_q[2*WORD_W-1:WORD_W] <= wdata_i;
        A_SENSE:   sense_q                   <= wdata_i & SENSE_OK;
        A_PRIO_A:  prio_a_q                  <= wdata_i;
        A_PRIO_B:  prio_b_q                  <= wdata_i;
        A_CFG:     cfg_q                     <= wdata_i[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_phys[WORD_W-1:0] =
    (wr_en_i && addr_i == A_PEND_LO) ? wdata_i : '0;
  assign clr_phys[2*WORD_W-1:WORD_W] =
    (wr_en_i && addr_i == A_PEND_HI) ? wdata_i : '0;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    localparam int P = phys_idx(s);
    assign mask_src[s]  = mask_q[P];
    assign clr_src[s]   = clr_phys[P];
    assign pend_phys[P] = pend_src[s];
  end

  sirq_sync #(.NUM(NUM_SRC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .async_ni(src_ni),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  sirq_pend u_pend (
    .clk_i, .rst_ni, .lvl_i(lvl), .fall_i(fall), .rise_i(rise),
    .sense_i(sense_q), .clr_i(clr_src), .pend_o(pend_src)
  );

  sirq_prio #(.NUM(NUM_SRC), .ID_W(ID_W)) u_prio (
    .req_i(pend_src & mask_src), .any_o(any_req), .id_o(vec_id)
  );

  assign irq_o = any_req;

  always_comb begin
    case (addr_i)
      A_MASK_LO: rdata_o = mask_q[WORD_W-1:0];
      A_MASK_HI: rdata_o = mask_q[2*WORD_W-1:WORD_W];
      A_PEND_LO: rdata_o = pend_phys[WORD_W-1:0];
      A_PEND_HI: rdata_o = pend_phys[2*WORD_W-1:WORD_W];
      A_SENSE:   rdata_o = sense_q;
      A_VEC:     rdata_o = {vec_id, {(WORD_W-ID_W){1'b0}}};
      A_PRIO_A:  rdata_o = prio_a_q;
      A_PRIO_B:  rdata_o = prio_b_q;
      A_CFG:     rdata_o = {{(WORD_W-CFG_W){1'b0}}, cfg_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk
  import sirq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [WORD_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic [63:0]        mask_q,
  input logic [63:0]        pend_phys,
  input logic [WORD_W-1:0]  sense_q,
  input logic [ID_W-1:0]    vec_id
);
  // edges seen since reset release, saturating; latency fixed at 3 for default sync depth
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  always_comb begin
    if (!rst_ni) a_r1_idle_in_reset: assert (!irq_o && pend_phys == '0);
  end

  a_r3_irq_needs_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend_phys & mask_q));

  a_r8_vec_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_id != '0));

  // source 1 is fixed level, physical bit 15
  a_r4_level_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd3) |-> (pend_phys[15] == !$past(src_ni[1], 3)));

  // source 19: sense bit 14, physical bit 46 (high bit 14)
  a_r5_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_q[14] && pend_phys[46] &&
     !(wr_en_i && addr_i == A_PEND_HI && wdata_i[14])) |=> pend_phys[46]);

  a_r12_mask_lo_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_MASK_LO) |=> $stable(mask_q[31:0]));
endmodule

bind sirq_ctrl sirq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_ni(src_ni), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o), .mask_q(mask_q),
  .pend_phys(pend_phys), .sense_q(sense_q), .vec_id(vec_id)
);

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] cur_lvl = '1;
  logic [63:0] exp_pend = '0;
  logic [63:0] exp_mask_phys = '0;
  logic [31:0] exp_sense = '0;

  always #5 clk = ~clk;

  sirq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_ni(src_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int b_phys(int s);
    if (s == 0)  return 0;
    if (s <= 15) return 16 - s;
    if (s <= 18) return 50 - s;
    if (s <= 30) return 65 - s;
    if (s == 31) return 47;
    if (s <= 47) return 63 - s;
    return s;
  endfunction

  function automatic int b_cls(int s);
    if (s >= 19 && s <= 25) return 1;
    if (s >= 48) return 2;
    return 0;
  endfunction

  function automatic int b_spos(int s);
    return (b_cls(s) == 1) ? 33 - s : s - 32;
  endfunction

  function automatic bit b_edge(int s);
    if (b_cls(s) == 2) return 1;
    if (b_cls(s) == 1) return exp_sense[b_spos(s)];
    return 0;
  endfunction

  function automatic logic [63:0] b_pend_phys();
    logic [63:0] p = '0;
    for (int s = 0; s < 64; s++) p[b_phys(s)] = exp_pend[s];
    return p;
  endfunction

  function automatic logic [31:0] b_vec();
    for (int s = 1; s < 64; s++)
      if (exp_pend[s] && exp_mask_phys[b_phys(s)]) return 32'(s) << 26;
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic verify(string tag);
    logic [31:0] v;
    logic [63:0] p = b_pend_phys();
    bus_read(4'd2, v); chk({tag, " R2 pend_lo"}, v, p[31:0]);
    bus_read(4'd3, v); chk({tag, " R2 pend_hi"}, v, p[63:32]);
    bus_read(4'd5, v); chk({tag, " R8 vector"}, v, b_vec());
    chk({tag, " R3 irq"}, 32'(irq), 32'(b_vec() != 0));
  endtask

  task automatic apply(logic [63:0] nv);
    for (int s = 1; s < 64; s++) begin
      if (!b_edge(s)) exp_pend[s] = ~nv[s];
      else if (cur_lvl[s] && !nv[s]) exp_pend[s] = 1'b1;
      else if (b_cls(s) == 2 && !exp_sense[b_spos(s)] && !cur_lvl[s] && nv[s])
        exp_pend[s] = 1'b1;
    end
    cur_lvl = nv; src_n = nv;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic w1c(bit hi, logic [31:0] d);
    for (int s = 1; s < 64; s++)
      if (b_edge(s) && (b_phys(s) / 32 == int'(hi)) && d[b_phys(s) % 32]) exp_pend[s] = 1'b0;
    bus_write(hi ? 4'd3 : 4'd2, d);
  endtask

  task automatic set_mask(bit hi, logic [31:0] d);
    if (hi) exp_mask_phys[63:32] = d; else exp_mask_phys[31:0] = d;
    bus_write(hi ? 4'd1 : 4'd0, d);
  endtask

  task automatic set_sense(logic [31:0] d);
    exp_sense = d & 32'hFFFF7F00;
    bus_write(4'd4, d);
    @(posedge clk); @(negedge clk);
    for (int s = 1; s < 64; s++) if (!b_edge(s)) exp_pend[s] = ~cur_lvl[s];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(4'd0, v); chk("R1 mask_lo", v, 0);
    bus_read(4'd1, v); chk("R1 mask_hi", v, 0);
    bus_read(4'd4, v); chk("R1 sense", v, 0);
    bus_read(4'd6, v); chk("R1 prio_a", v, 32'h05309770);
    bus_read(4'd7, v); chk("R1 prio_b", v, 32'h05309770);
    bus_read(4'd8, v); chk("R1 cfg", v, 0);
    verify("R1");

    // R10 / R11 / R12 storage
    bus_write(4'd4, '1); bus_read(4'd4, v); chk("R10 sense mask", v, 32'hFFFF7F00);
    bus_write(4'd4, '0);
    bus_write(4'd6, 32'hA5A5_1234); bus_read(4'd6, v); chk("R11 prio_a", v, 32'hA5A5_1234);
    bus_write(4'd7, 32'h0F0F_CAFE); bus_read(4'd7, v); chk("R11 prio_b", v, 32'h0F0F_CAFE);
    bus_write(4'd8, '1); bus_read(4'd8, v); chk("R11 cfg width", v, 32'h0000_FFFF);
    bus_write(4'd5, '1); bus_read(4'd5, v); chk("R12 vector write ignored", v, 0);
    bus_read(4'd0, v); chk("R12 mask untouched", v, 0);

    // R3 pending without enable
    apply(~(64'd1 << 5)); verify("R3 masked");
    chk("R3 irq masked off", 32'(irq), 0);
    set_mask(0, '1); set_mask(1, '1);
    verify("R3 enabled");
    apply('1); verify("R4 release");

    // R4 exact latency and write-one immunity
    src_n[5] = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 not yet at 2 edges", 32'(irq), 0);
    @(posedge clk); @(negedge clk);
    chk("R4 visible at 3 edges", 32'(irq), 1);
    cur_lvl[5] = 1'b0; exp_pend[5] = 1'b1;
    w1c(0, '1); verify("R4 w1c no effect");
    apply('1); verify("R4 follows input");

    // R2 / R9 sweep over every source
    for (int s = 0; s < 64; s++) begin
      apply(~(64'd1 << s)); verify("R2 sweep low");
      apply('1);
      w1c(0, '1); w1c(1, '1); verify("R7 sweep clear");
    end
    apply(~64'd1); verify("R9 source0");
    chk("R9 irq quiet", 32'(irq), 0);
    apply('1);

    // R5 external source 19
    set_sense(32'h1 << 14);
    apply(~(64'd1 << 19)); apply('1); verify("R5 edge held");
    bus_read(4'd3, v); chk("R5 latched bit", v, 32'h1 << 14);
    w1c(1, 32'h1 << 14); verify("R5 cleared");
    set_sense('0);
    apply(~(64'd1 << 19)); verify("R5 level low");
    apply('1); verify("R5 level released");

    // R6 port source 50, sense bit 18, high bit 18
    apply(~(64'd1 << 50)); w1c(1, '1);
    apply('1); bus_read(4'd3, v); chk("R6 rising sets", v, 32'h1 << 18);
    w1c(1, '1);
    set_sense(32'h1 << 18);
    apply(~(64'd1 << 50)); bus_read(4'd3, v); chk("R6 falling sets", v, 32'h1 << 18);
    w1c(1, '1);
    apply('1); bus_read(4'd3, v); chk("R6 rising ignored", v, 0);
    verify("R6");

    // R7 partial clear, R8 ordering
    set_sense('0);
    apply(~((64'd1 << 48) | (64'd1 << 60) | (64'd1 << 7) | (64'd1 << 40)));
    bus_read(4'd5, v); chk("R8 lowest wins", v, 32'd7 << 26);
    set_mask(0, ~(32'h1 << 9)); bus_read(4'd5, v); chk("R8 next lowest", v, 32'd40 << 26);
    apply('1);
    w1c(1, 32'h1 << 16); verify("R7 partial clear");
    set_mask(0, '1);
    w1c(1, '1); verify("R7 full clear");

    // random phase
    set_sense($urandom());
    set_mask(0, $urandom()); set_mask(1, $urandom());
    for (int i = 0; i < 300; i++) begin
      logic [63:0] flip = {$urandom(), $urandom()} & {$urandom(), $urandom()}
                          & {$urandom(), $urandom()};
      apply(cur_lvl ^ flip);
      verify("rand");
      if (($urandom() % 4) == 0) w1c($urandom() % 2 == 1, $urandom());
      if (($urandom() % 16) == 0) set_mask($urandom() % 2 == 1, $urandom());
      if (($urandom() % 32) == 0) set_sense($urandom());
    end
    verify("rand end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule